// File: doc/BRIEF.md
# Two-Step Taken-Branch Predictor

This block gives a fetch unit an early guess about each branch, and gives a dispatch unit a second, more accurate guess. At fetch, the fetch address is looked up in a small two-way set-associative target cache. The cache holds only branches that are expected to be taken. A hit predicts taken and supplies the stored target as the next fetch address. A miss predicts fall-through. At dispatch, a tagless direct-mapped table of 2-bit saturating counters gives a second direction. When that direction differs from the one used at fetch, the dispatch result wins and the block raises a redirect, which costs the front end one cycle.

When a branch resolves, the block updates the counter for that branch and then maintains the target cache from the new counter value. Direct unconditional branches and PC-relative conditional branches are filled, refreshed or dropped. Branches whose target comes from a register are never placed in the cache, so fetch always predicts them as not taken.

All three ports are plain and have no back-pressure. The lookups are combinational. An update is taken on every clock edge at which `upd_valid` is high. The lookups read the state as it was before any update in the same cycle.

Top module: `twophase_bpred`

## Requirements
- R1: After reset, no fetch address hits in the target cache, and every counter holds 1, so an unresolved dispatch predicts not taken.
- R2: A fetch hit drives `fetch_taken`=1 and `fetch_target`=stored target. A miss drives `fetch_taken`=0 and `fetch_target`=`fetch_pc`+4. Address bits [1:0] are ignored.
- R3: An update with kind 0 (direct unconditional) always installs or refreshes the entry. An update with kind 1 (PC-relative conditional) does so only when its counter, after the update, is 2 or 3.
- R4: An update with kind 2 or 3 (register-target) never installs into the target cache, but it still updates its counter.
- R5: For kinds 1 to 3, an update moves the counter up by one when taken and down by one when not taken, saturating at 0 and 3. Counter values 2 and 3 predict taken.
- R6: When `disp_resolved`=1, `disp_taken` equals `disp_resolved_taken` and the counter is ignored. Otherwise `disp_taken` is bit 1 of the counter.
- R7: `disp_redirect` is 1 exactly when `disp_valid`=1 and `disp_taken` differs from `disp_fetch_taken`.
- R8: A kind 1 update that leaves its counter below 2 invalidates that branch's target-cache entry if the branch has one.
- R9: The counter index is `pc[log2(DT_ENTRIES)+1:2]` and has no tag. Addresses that differ by a multiple of DT_ENTRIES*4 share a counter.
- R10: The target-cache set is `pc[log2(TC_SETS)+1:2]`. Each set has one LRU bit. A hit refreshes its way. A fill goes to the LRU way. An eviction makes the freed way the next one to fill.
- R11: A kind 0 update leaves its counter unchanged.
- R12: A fetch or dispatch lookup in the same cycle as an update sees the state from before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_pc | input | ADDR_W | Address being fetched |
| fetch_taken | output | 1 | Fetch-time prediction: taken |
| fetch_target | output | ADDR_W | Next fetch address |
| disp_valid | input | 1 | A branch is at dispatch |
| disp_pc | input | ADDR_W | Address of the dispatching branch |
| disp_fetch_taken | input | 1 | Direction that was used at fetch |
| disp_resolved | input | 1 | The direction is already known (condition ready, or unconditional) |
| disp_resolved_taken | input | 1 | The known direction |
| disp_taken | output | 1 | Final dispatch-time direction |
| disp_redirect | output | 1 | Dispatch overrides the fetch guess |
| upd_valid | input | 1 | A resolved branch update |
| upd_pc | input | ADDR_W | Address of the resolved branch |
| upd_kind | input | 2 | 0 direct unconditional, 1 PC-relative conditional, 2/3 register target |
| upd_taken | input | 1 | Actual direction |
| upd_target | input | ADDR_W | Actual target |

## Verification
The bench targets the following corner cases, and what a faulty design would do in each:
- **Counter at its limits.** A counter that wraps instead of saturating would predict taken after a long not-taken run.
- **Eviction threshold.** A design that evicted or filled at the wrong counter value would leave stale hits, or miss where the cache should hit.
- **LRU victim choice.** A third tag landing in a full set must evict the least recently touched way. A wrong choice shows up as a lost hit on the branch that should have stayed.
- **Other sequences.** The bench also checks counter aliasing between distant addresses, register-target branches that must never hit, unconditional updates that must not touch counters, and lookups that run alongside an update to the same address. A long pseudo-random sweep compares every update against an arithmetic model of the counters and the sets.

// File: rtl/bpred_pkg.sv
package bpred_pkg;
  typedef enum logic [1:0] {
    BR_UNCOND   = 2'd0,
    BR_COND_REL = 2'd1,
    BR_REG_A    = 2'd2,
    BR_REG_B    = 2'd3
  } br_kind_e;
endpackage

// File: rtl/bpred_dir_table.sv
module bpred_dir_table #(
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 2048
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rd_pc,
  output logic              rd_taken,
  input  logic              up_en,
  input  logic [ADDR_W-1:0] up_pc,
  input  logic              up_taken,
  output logic              up_next_taken
);
  localparam int IDX_W = $clog2(ENTRIES);

  logic [1:0]       ctr_q [ENTRIES];
  logic [IDX_W-1:0] rd_idx, up_idx;
  logic [1:0]       up_old, up_next;

  assign rd_idx   = rd_pc[IDX_W+1:2];
  assign up_idx   = up_pc[IDX_W+1:2];
  assign rd_taken = ctr_q[rd_idx][1];
  assign up_old   = ctr_q[up_idx];

  always_comb begin
    if (up_taken) up_next = (up_old == 2'd3) ? 2'd3 : up_old + 2'd1;
    else          up_next = (up_old == 2'd0) ? 2'd0 : up_old - 2'd1;
  end
  assign up_next_taken = up_next[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) ctr_q[i] <= 2'd1;
    end else if (up_en) begin
      ctr_q[up_idx] <= up_next;
    end
  end

  // R5: a taken update never leaves the counter at 0; a not-taken one never at 3
  p_taken_floor_r5: assert property (@(posedge clk) disable iff (!rst_n)
    up_en && up_taken |=> ctr_q[$past(up_idx)] != 2'd0);
  p_nt_ceiling_r5: assert property (@(posedge clk) disable iff (!rst_n)
    up_en && !up_taken |=> ctr_q[$past(up_idx)] != 2'd3);
endmodule

// File: rtl/bpred_target_cache.sv
module bpred_target_cache #(
  parameter int ADDR_W = 32,
  parameter int SETS   = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] lk_pc,
  output logic              lk_hit,
  output logic [ADDR_W-1:0] lk_target,
  input  logic [ADDR_W-1:0] up_pc,
  input  logic              up_install,
  input  logic              up_evict,
  input  logic [ADDR_W-1:0] up_target
);
  localparam int WAYS  = 2;
  localparam int SET_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - SET_W - 2;

  logic [WAYS-1:0]   vld_q   [SETS];
  logic [TAG_W-1:0]  tag_q   [SETS][WAYS];
  logic [ADDR_W-1:0] tgt_q   [SETS][WAYS];
  logic              lru_q   [SETS];

  logic [SET_W-1:0] lk_set, up_set;
  logic [TAG_W-1:0] lk_tag, up_tag;
  logic [WAYS-1:0]  lk_hit_vec, up_hit_vec;
  logic             up_hit, up_hit_way, fill_way;

  assign lk_set = lk_pc[SET_W+1:2];
  assign lk_tag = lk_pc[ADDR_W-1:SET_W+2];
  assign up_set = up_pc[SET_W+1:2];
  assign up_tag = up_pc[ADDR_W-1:SET_W+2];

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign lk_hit_vec[w] = vld_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag);
    assign up_hit_vec[w] = vld_q[up_set][w] && (tag_q[up_set][w] == up_tag);
  end

  assign lk_hit     = |lk_hit_vec;
  assign lk_target  = lk_hit_vec[1] ? tgt_q[lk_set][1] : tgt_q[lk_set][0];
  assign up_hit     = |up_hit_vec;
  assign up_hit_way = up_hit_vec[1];
  assign fill_way   = up_hit ? up_hit_way : lru_q[up_set];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        lru_q[s] <= 1'b0;
      end
    end else if (up_install) begin
      vld_q[up_set][fill_way] <= 1'b1;
      lru_q[up_set]           <= ~fill_way;
    end else if (up_evict && up_hit) begin
      vld_q[up_set][up_hit_way] <= 1'b0;
      lru_q[up_set]             <= up_hit_way;
    end
  end

  always_ff @(posedge clk) begin
    if (up_install) begin
      tag_q[up_set][fill_way] <= up_tag;
      tgt_q[up_set][fill_way] <= up_target;
    end
  end

  // R10: a tag never sits in both ways of a set
  p_one_hit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_hit_vec));
  // R3: a fill leaves a valid way behind
  p_fill_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    up_install |=> vld_q[$past(up_set)][$past(fill_way)]);
  // R8: an eviction clears the way that held the branch
  p_evict_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    up_evict && !up_install && up_hit |=> !vld_q[$past(up_set)][$past(up_hit_way)]);
endmodule

// File: rtl/twophase_bpred.sv
module twophase_bpred
  import bpred_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int TC_SETS    = 128,
  parameter int DT_ENTRIES = 2048
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] fetch_pc,
  output logic              fetch_taken,
  output logic [ADDR_W-1:0] fetch_target,
  input  logic              disp_valid,
  input  logic [ADDR_W-1:0] disp_pc,
  input  logic              disp_fetch_taken,
  input  logic              disp_resolved,
  input  logic              disp_resolved_taken,
  output logic              disp_taken,
  output logic              disp_redirect,
  input  logic              upd_valid,
  input  logic [ADDR_W-1:0] upd_pc,
  input  logic [1:0]        upd_kind,
  input  logic              upd_taken,
  input  logic [ADDR_W-1:0] upd_target
);
  br_kind_e          kind;
  logic              tc_hit, dt_taken, ctr_en, ctr_next_taken, tc_install, tc_evict;
  logic [ADDR_W-1:0] tc_target;

  assign kind = br_kind_e'(upd_kind);

  bpred_target_cache #(.ADDR_W(ADDR_W), .SETS(TC_SETS)) u_tc (
    .clk(clk), .rst_n(rst_n),
    .lk_pc(fetch_pc), .lk_hit(tc_hit), .lk_target(tc_target),
    .up_pc(upd_pc), .up_install(tc_install), .up_evict(tc_evict),
    .up_target(upd_target)
  );

  bpred_dir_table #(.ADDR_W(ADDR_W), .ENTRIES(DT_ENTRIES)) u_dt (
    .clk(clk), .rst_n(rst_n),
    .rd_pc(disp_pc), .rd_taken(dt_taken),
    .up_en(ctr_en), .up_pc(upd_pc), .up_taken(upd_taken),
    .up_next_taken(ctr_next_taken)
  );

  assign fetch_taken  = tc_hit;
  assign fetch_target = tc_hit ? tc_target : fetch_pc + ADDR_W'(4);

  assign disp_taken    = disp_resolved ? disp_resolved_taken : dt_taken;
  assign disp_redirect = disp_valid && (disp_taken != disp_fetch_taken);

  assign ctr_en     = upd_valid && (kind != BR_UNCOND);
  assign tc_install = upd_valid &&
                      ((kind == BR_UNCOND) || (kind == BR_COND_REL && ctr_next_taken));
  assign tc_evict   = upd_valid && (kind == BR_COND_REL) && !ctr_next_taken;

  // R7: a redirect means a branch is present and the two guesses disagree
  p_redirect_r7: assert property (@(posedge clk) disable iff (!rst_n)
    disp_redirect |-> disp_valid && (disp_taken != disp_fetch_taken));
  // R6: a known direction passes straight through
  p_resolved_r6: assert property (@(posedge clk) disable iff (!rst_n)
    disp_resolved |-> disp_taken == disp_resolved_taken);
  // R4: register-target branches never reach the fill path
  p_reg_no_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid && upd_kind[1] |-> !tc_install);
endmodule

// File: tb/tb_twophase_bpred.sv
module tb_twophase_bpred;
  localparam int AW = 16, SETS = 4, DTE = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] fetch_pc = '0, disp_pc = '0, upd_pc = '0, upd_target = '0;
  logic fetch_taken, disp_taken, disp_redirect;
  logic [AW-1:0] fetch_target;
  logic disp_valid = 0, disp_fetch_taken = 0, disp_resolved = 0, disp_resolved_taken = 0;
  logic upd_valid = 0, upd_taken = 0;
  logic [1:0] upd_kind = '0;

  always #4 clk = ~clk;

  twophase_bpred #(.ADDR_W(AW), .TC_SETS(SETS), .DT_ENTRIES(DTE)) dut (.*);

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // arithmetic reference state
  int m_ctr [DTE];
  bit m_vld [SETS][2];
  int m_tag [SETS][2];
  int m_tgt [SETS][2];
  int m_lru [SETS];

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int hit_way(input int pc);
    int s = (pc >> 2) % SETS, t = pc >> 4;
    for (int w = 0; w < 2; w++) if (m_vld[s][w] && m_tag[s][w] == t) return w;
    return -1;
  endfunction

  task automatic model_update(input int pc, input int kind, input bit tk, input int tgt);
    int di = (pc >> 2) % DTE, s = (pc >> 2) % SETS, hw = hit_way(pc), w;
    int nc = m_ctr[di];
    if (kind != 0) begin
      nc = tk ? ((nc == 3) ? 3 : nc + 1) : ((nc == 0) ? 0 : nc - 1);
      m_ctr[di] = nc;
    end
    if (kind == 0 || (kind == 1 && nc >= 2)) begin
      w = (hw >= 0) ? hw : m_lru[s];
      m_vld[s][w] = 1; m_tag[s][w] = pc >> 4; m_tgt[s][w] = tgt; m_lru[s] = 1 - w;
    end else if (kind == 1 && hw >= 0) begin
      m_vld[s][hw] = 0; m_lru[s] = hw;
    end
  endtask

  task automatic do_update(input int pc, input int kind, input bit tk, input int tgt);
    @(negedge clk);
    upd_pc = AW'(pc); upd_kind = 2'(kind); upd_taken = tk; upd_target = AW'(tgt);
    upd_valid = 1;
    @(posedge clk); #1;
    upd_valid = 0;
    model_update(pc, kind, tk, tgt);
  endtask

  task automatic check_fetch(input int pc, input string req);
    int hw;
    @(negedge clk);
    fetch_pc = AW'(pc); #1;
    hw = hit_way(pc);
    chk({req, " fetch_taken"}, int'(fetch_taken), (hw >= 0) ? 1 : 0);
    chk({req, " fetch_target"}, int'(fetch_target),
        (hw >= 0) ? m_tgt[(pc >> 2) % SETS][hw] : ((pc + 4) & 16'hffff));
  endtask

  task automatic check_disp(input int pc, input bit fp, input bit res, input bit rt, input string req);
    bit fin;
    @(negedge clk);
    disp_valid = 1; disp_pc = AW'(pc); disp_fetch_taken = fp;
    disp_resolved = res; disp_resolved_taken = rt; #1;
    fin = res ? rt : (m_ctr[(pc >> 2) % DTE] >= 2);
    chk({req, " disp_taken"}, int'(disp_taken), int'(fin));
    chk({req, " disp_redirect"}, int'(disp_redirect), int'(fin != fp));
    disp_valid = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int seed = 32'h1234_5678;
    for (int i = 0; i < DTE; i++) m_ctr[i] = 1;
    for (int s = 0; s < SETS; s++) begin
      m_lru[s] = 0; m_vld[s][0] = 0; m_vld[s][1] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R1 reset state across every set and counter
    for (int p = 0; p < DTE * 4; p += 4) begin
      check_fetch(p, "R1");
      check_disp(p, 1'b0, 1'b0, 1'b0, "R1");
    end

    // R2 R3 R11: unconditional install, counter untouched
    do_update(16'h0100, 0, 1, 16'h2220);
    check_fetch(16'h0100, "R2");
    check_fetch(16'h0103, "R2 low bits");
    check_disp(16'h0100, 1'b1, 1'b0, 1'b0, "R11");

    // R5 R3 R8: climb, saturate, fall, evict, floor
    do_update(16'h0204, 1, 1, 16'h0400); check_fetch(16'h0204, "R3 fill at 2");
    do_update(16'h0204, 1, 1, 16'h0400);
    do_update(16'h0204, 1, 1, 16'h0400);
    do_update(16'h0204, 1, 1, 16'h0400); check_disp(16'h0204, 1'b0, 1'b0, 1'b0, "R5 high");
    do_update(16'h0204, 1, 0, 16'h0400); check_fetch(16'h0204, "R8 still at 2");
    do_update(16'h0204, 1, 0, 16'h0400); check_fetch(16'h0204, "R8 evict at 1");
    do_update(16'h0204, 1, 0, 16'h0400);
    do_update(16'h0204, 1, 0, 16'h0400);
    do_update(16'h0204, 1, 0, 16'h0400);
    do_update(16'h0204, 1, 1, 16'h0400); check_disp(16'h0204, 1'b1, 1'b0, 1'b0, "R5 floor");

    // R4: register-target branches train the counter but never hit
    for (int k = 0; k < 3; k++) do_update(16'h0308, 2 + (k & 1), 1, 16'h0500);
    check_fetch(16'h0308, "R4");
    check_disp(16'h0308, 1'b0, 1'b0, 1'b0, "R4 counter");

    // R9: aliasing across DTE*4 bytes
    do_update(16'h040c, 2, 1, 0);
    do_update(16'h040c, 2, 1, 0);
    check_disp(16'h040c + DTE * 4, 1'b0, 1'b0, 1'b0, "R9");

    // R10: three tags in one set
    do_update(16'h0a00, 0, 1, 16'h1000); check_fetch(16'h0a00, "R10");
    do_update(16'h0a10, 0, 1, 16'h1100); check_fetch(16'h0a10, "R10");
    do_update(16'h0a20, 0, 1, 16'h1200);
    check_fetch(16'h0a00, "R10 victim"); check_fetch(16'h0a20, "R10");
    do_update(16'h0a10, 0, 1, 16'h1110);
    do_update(16'h0a00, 0, 1, 16'h1001);
    check_fetch(16'h0a20, "R10 lru"); check_fetch(16'h0a10, "R10"); check_fetch(16'h0a00, "R10");

    // R6 R7: all dispatch combinations
    for (int c = 0; c < 8; c++)
      check_disp(16'h0204, c[0], c[1], c[2], "R6 R7");

    // R12: same-cycle lookup sees old state
    @(negedge clk);
    fetch_pc = 16'h0b00; disp_pc = 16'h0b00; disp_valid = 1;
    disp_resolved = 0; disp_fetch_taken = 0;
    upd_pc = 16'h0b00; upd_kind = 2'd1; upd_taken = 1; upd_target = 16'h3000; upd_valid = 1;
    #1;
    chk("R12 fetch", int'(fetch_taken), 0);
    chk("R12 disp", int'(disp_taken), 0);
    @(posedge clk); #1;
    upd_valid = 0; disp_valid = 0;
    model_update(16'h0b00, 1, 1, 16'h3000);
    check_fetch(16'h0b00, "R12 after");

    // sweep against the model
    for (int n = 0; n < 600; n++) begin
      int pc, kd;
      seed = seed * 1103515245 + 12345;
      pc = ((seed >>> 8) & 8'hff) << 2;
      kd = (seed >>> 20) & 3;
      do_update(pc, kd, seed[27], (seed >>> 4) & 16'hfffc);
      check_fetch(pc, "R3 R8 R10 sweep");
      check_disp(pc, seed[29], seed[30] & seed[31], seed[28], "R5 R6 sweep");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule